// File: doc/BRIEF.md
# Strobe-Serial Byte Memory Slave

This block is the device side of a small byte memory (512 bytes by default) that a host reaches through an ordinary microprocessor-style strobe interface. The interface has an active-low select, an active-low read strobe, an active-low write strobe and one data bit. Every host write strobe delivers one bit into the block. Every host read strobe fetches one bit from it. The block first collects a 16-bit address, most significant bit first. It then hands out data bytes one bit at a time, and moves to the next byte address by itself after each byte.

The host uses the same strobes to restart the block. A read, then a write of 0, then a read forms an in-band restart. It drops any address collection or streaming read that is in progress and arms a write-enable latch. The latch, gated by an active-low write-protect pin, produces the permission that a nonvolatile programming engine would need. That engine is modelled here only by a busy input. The strobes, the data input and the protect pin are oversampled by the system clock through two-stage synchronizers. A strobe cycle counts as finished when the synchronized strobe combination leaves the write or read state. The storage is a register array that is preset at reset to a fixed pattern.

Top module: `ssm_top`

## Requirements
- R1: A write cycle is select low, write strobe low and read strobe high. It takes the data bit present while the write strobe or the select is low, and the cycle ends when either of them rises.
- R2: `dio_oe` is 1 only while `cs_n`=0, `oe_n`=0 and `we_n`=1. It is 0 whenever the select is high or the write strobe is low.
- R3: In address phase, 16 finished write cycles, with no read between them, form an address sent MSB first. Only the low 9 bits select a byte, and the upper 7 are dropped. A read during address collection returns 1 and starts the count again from zero.
- R4: After the 16th address bit, each group of 8 read cycles returns one stored byte, MSB first on `dio_o`.
- R5: The byte pointer advances by one after every 8th read. From 0x1FF it wraps to 0x000, and reading can go on without limit.
- R6: A finished write of 0 directly after a counted read restarts the block: it enters address phase with a zero count and sets the write-enable latch. A read that directly follows such a restart is not counted for this rule. While `nv_busy`=1 the write of 0 is ignored and the bit count of the byte being read goes on unchanged.
- R7: Every read returns 1 while no complete address has been received. This holds after power-up reset and after an in-band restart.
- R8: `nv_wr_allow` equals the write-enable latch ANDed with the synchronized `wp_n`. The latch is 0 after `rst_n`. While `wp_n`=0 no new permission is given.
- R9: With `cs_n`, `we_n` and `oe_n` all 0, `proto_err` is 1 and `dio_oe` is 0. Such an interval moves neither the byte pointer nor the bit count.
- R10: In data phase, a finished write that does not form a restart has no effect on the byte pointer or the bit count.
- R11: After reset, the byte at address a holds (a[7:0] + (a[8] ? 0x71 : 0x13)) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| oe_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| wp_n | input | 1 | Active-low write protect |
| nv_busy | input | 1 | Nonvolatile programming in progress |
| dio_i | input | 1 | Data bit from the host |
| dio_o | output | 1 | Data bit to the host |
| dio_oe | output | 1 | Drive enable for the data pin |
| nv_wr_allow | output | 1 | Nonvolatile write permission |
| proto_err | output | 1 | Both strobes low while selected |

## Verification
The properties assume that every strobe level and every data-bit level lasts long enough for the two-stage synchronizers to see it. They also assume that the data bit stays steady from before a write strobe falls until after the strobe rises, so each finished cycle is decoded exactly once with the intended bit. The stimulus changes the pins only on falling clock edges. It holds each strobe low for at least four clocks and high for at least six. It sets the data bit one clock before the write strobe falls and holds it for four clocks after the strobe rises. The protect and busy inputs change only while no strobe is active.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    typedef enum logic [1:0] {
        CY_IDLE = 2'd0,
        CY_WR   = 2'd1,
        CY_RD   = 2'd2,
        CY_ERR  = 2'd3
    } cyc_e;

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

endpackage

// File: rtl/ssm_sync.sv
module ssm_sync #(
    parameter int W        = 1,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= {W{RST_VAL}};
            s2_q <= {W{RST_VAL}};
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;

endmodule

// File: rtl/ssm_cycle_dec.sv
module ssm_cycle_dec
    import ssm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic oe_s,
    input  logic we_s,
    input  logic dio_s,
    output cyc_e kind,
    output logic wr_done,
    output logic rd_done,
    output logic wbit
);

    typedef struct packed {
        cyc_e kind;
        logic wbit;
    } dec_t;

    dec_t q, d;
    cyc_e cur;

    always_comb begin
        // classify the synchronized strobe combination
        if (cs_s)
            cur = CY_IDLE;
        else if (!we_s && !oe_s)
            cur = CY_ERR;
        else if (!we_s)
            cur = CY_WR;
        else if (!oe_s)
            cur = CY_RD;
        else
            cur = CY_IDLE;

        d      = q;
        d.kind = cur;
        if (cur == CY_WR)
            d.wbit = dio_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{kind: CY_IDLE, wbit: 1'b1};
        end else begin
            q <= d;
        end
    end

    // a cycle finishes when the combination leaves its state
    assign wr_done = (q.kind == CY_WR) && (cur != CY_WR);
    assign rd_done = (q.kind == CY_RD) && (cur != CY_RD);
    assign wbit    = q.wbit;
    assign kind    = cur;

endmodule

// File: rtl/ssm_store.sv
module ssm_store #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    function automatic logic [DW-1:0] preset(input int idx);
        logic [AW-1:0] a;
        a = AW'(idx);
        return DW'(a) + (a[AW-1] ? DW'(8'h71) : DW'(8'h13));
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= preset(i);
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/ssm_top.sv
module ssm_top
    import ssm_pkg::*;
#(
    parameter int ADDR_LEN = 16,
    parameter int AW       = 9,
    parameter int DW       = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic wp_n,
    input  logic nv_busy,
    input  logic dio_i,
    output logic dio_o,
    output logic dio_oe,
    output logic nv_wr_allow,
    output logic proto_err
);

    localparam int CNT_W = $clog2(ADDR_LEN);
    localparam int BIT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_LEN - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DW - 1);

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    acnt;
        logic [ADDR_LEN-1:0] ashift;
        logic [AW-1:0]       ptr;
        logic [BIT_W-1:0]    bitn;
        logic                prev_rd;
        logic                post_rst;
        logic                wel;
        logic                outb;
        logic                err;
    } st_t;

    st_t q, d;

    // synchronized pins: cs, oe, we, dio, wp
    logic [4:0] pins_s;
    logic       cs_s, oe_s, we_s, dio_s, wp_s;

    ssm_sync #(.W(5), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, oe_n, we_n, dio_i, wp_n}),
        .dout (pins_s)
    );

    assign {cs_s, oe_s, we_s, dio_s, wp_s} = pins_s;

    cyc_e kind;
    logic wr_done, rd_done, wbit;

    ssm_cycle_dec u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_s   (cs_s),
        .oe_s   (oe_s),
        .we_s   (we_s),
        .dio_s  (dio_s),
        .kind   (kind),
        .wr_done(wr_done),
        .rd_done(rd_done),
        .wbit   (wbit)
    );

    logic [DW-1:0] rdata;

    ssm_store #(.AW(AW), .DW(DW)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .raddr(q.ptr),
        .rdata(rdata)
    );

    logic [ADDR_LEN-1:0] shift_nx;

    always_comb begin
        d        = q;
        shift_nx = {q.ashift[ADDR_LEN-2:0], wbit};
        d.err    = (kind == CY_ERR);

        if (wr_done) begin
            if (!wbit && q.prev_rd && !nv_busy) begin
                // in-band restart
                d.phase    = PH_ADDR;
                d.acnt     = '0;
                d.wel      = 1'b1;
                d.post_rst = 1'b1;
            end else if (q.phase == PH_ADDR) begin
                d.ashift = shift_nx;
                if (q.acnt == CNT_LAST) begin
                    d.phase = PH_DATA;
                    d.acnt  = '0;
                    d.ptr   = shift_nx[AW-1:0];
                    d.bitn  = '0;
                end else begin
                    d.acnt = q.acnt + 1'b1;
                end
            end
            d.prev_rd = 1'b0;
        end else if (rd_done) begin
            if (q.phase == PH_ADDR) begin
                d.acnt = '0;
            end else if (q.bitn == BIT_LAST) begin
                d.bitn = '0;
                d.ptr  = q.ptr + 1'b1;
            end else begin
                d.bitn = q.bitn + 1'b1;
            end
            d.prev_rd  = !q.post_rst;
            d.post_rst = 1'b0;
        end

        d.outb = (q.phase == PH_DATA) ? rdata[BIT_LAST - q.bitn] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_ADDR, acnt: '0, ashift: '0, ptr: '0, bitn: '0,
                   prev_rd: 1'b0, post_rst: 1'b0, wel: 1'b0, outb: 1'b1,
                   err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign dio_oe      = !cs_n && !oe_n && we_n;
    assign dio_o       = q.outb;
    assign nv_wr_allow = q.wel && wp_s;
    assign proto_err   = q.err;

    // observation points for the bound checker
    logic          in_data;
    logic [AW-1:0] ptr_q;
    logic          wel_q;
    logic          outb_q;

    assign in_data = (q.phase == PH_DATA);
    assign ptr_q   = q.ptr;
    assign wel_q   = q.wel;
    assign outb_q  = q.outb;

endmodule

// File: rtl/ssm_chk.sv
module ssm_chk #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          we_n,
    input logic          wp_n,
    input logic          nv_busy,
    input logic          dio_oe,
    input logic          nv_wr_allow,
    input logic          in_data,
    input logic [AW-1:0] ptr_q,
    input logic          wel_q,
    input logic          outb_q,
    input logic          wr_done
);

    // R5: inside data phase the pointer only ever steps by one
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && $past(in_data) && (ptr_q != $past(ptr_q)))
            |-> (ptr_q == AW'($past(ptr_q) + 1'b1)));

    // R3: data phase is entered only by a finished write
    a_r3_enter_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_data) |-> $past(wr_done));

    // R7: outside data phase the returned bit is 1
    a_r7_ones_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_data && $past(!in_data)) |-> outb_q);

    // R8: a steady low protect pin removes the permission
    a_r8_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && $past(!wp_n) && $past(!wp_n, 2)) |-> !nv_wr_allow);

    // R2: no drive while the write strobe is low and the select is active
    a_r2_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |-> !dio_oe);

    // R6: the latch is set only by a finished write while not busy
    a_r6_wel_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> ($past(wr_done) && !$past(nv_busy)));

endmodule

bind ssm_top ssm_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .we_n       (we_n),
    .wp_n       (wp_n),
    .nv_busy    (nv_busy),
    .dio_oe     (dio_oe),
    .nv_wr_allow(nv_wr_allow),
    .in_data    (in_data),
    .ptr_q      (ptr_q),
    .wel_q      (wel_q),
    .outb_q     (outb_q),
    .wr_done    (wr_done)
);

// File: tb/sim_ssm_top.sv
module sim_ssm_top;

    logic clk = 1'b0;
    logic rst_n, cs_n, oe_n, we_n, wp_n, nv_busy, dio_i;
    logic dio_o, dio_oe, nv_wr_allow, proto_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ssm_top u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .wp_n(wp_n), .nv_busy(nv_busy), .dio_i(dio_i), .dio_o(dio_o),
        .dio_oe(dio_oe), .nv_wr_allow(nv_wr_allow), .proto_err(proto_err)
    );

    // address (16 bits) and byte count (4 bits)
    localparam logic [19:0] VEC [5] = '{
        {16'h0000, 4'd2},
        {16'h0005, 4'd3},
        {16'hFE7F, 4'd2},
        {16'h01FE, 4'd3},
        {16'h8100, 4'd1}
    };

    function automatic logic [7:0] exp_byte(input logic [8:0] a);
        return a[7:0] + (a[8] ? 8'h71 : 8'h13);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_bit(input logic b);
        @(negedge clk);
        dio_i = b;
        wait_clk(1);
        cs_n = 1'b0; we_n = 1'b0;
        wait_clk(5);
        cs_n = 1'b1; we_n = 1'b1;
        wait_clk(4);
        dio_i = 1'b1;
        wait_clk(2);
    endtask

    task automatic rd_bit(output logic b, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0;
        wait_clk(3);
        b  = dio_o;
        oe = dio_oe;
        wait_clk(1);
        cs_n = 1'b1; oe_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic rd_byte(output logic [7:0] v, output logic all_oe);
        logic b, oe;
        all_oe = 1'b1;
        for (int i = 0; i < 8; i++) begin
            rd_bit(b, oe);
            v = {v[6:0], b};
            all_oe &= oe;
        end
    endtask

    task automatic send_addr(input logic [15:0] a);
        for (int i = 15; i >= 0; i--) wr_bit(a[i]);
    endtask

    task automatic restart_seq(output logic second_rd);
        logic b, oe;
        rd_bit(b, oe);
        wr_bit(1'b0);
        rd_bit(second_rd, oe);
    endtask

    task automatic hw_reset();
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_up();
        end
    end

    initial begin
        logic b, oe, sec;
        logic [7:0] v;
        logic [8:0] p;

        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; wp_n = 1'b1;
        nv_busy = 1'b0; dio_i = 1'b1; rst_n = 1'b0;
        hw_reset();

        // reset state
        chk(dio_oe == 1'b0, "R2 idle hi-z", dio_oe, 0);
        chk(proto_err == 1'b0, "R9 idle no error", proto_err, 0);
        chk(nv_wr_allow == 1'b0, "R8 latch clear after reset", nv_wr_allow, 0);
        rd_bit(b, oe);
        chk(b == 1'b1, "R7 power-up read is 1", b, 1);
        chk(oe == 1'b1, "R2 drive during read", oe, 1);

        // in-band restart
        restart_seq(sec);
        chk(sec == 1'b1, "R6 R7 second read of restart is 1", sec, 1);
        wait_clk(2);
        chk(nv_wr_allow == 1'b1, "R6 R8 latch set by restart", nv_wr_allow, 1);

        // vector table: restart, address, sequential bytes
        foreach (VEC[k]) begin
            restart_seq(sec);
            send_addr(VEC[k][19:4]);
            p = VEC[k][12:4];
            for (int n = 0; n < int'(VEC[k][3:0]); n++) begin
                rd_byte(v, oe);
                chk(v == exp_byte(p), "R3 R4 R5 R11 byte", v, exp_byte(p));
                chk(oe == 1'b1, "R2 drive on data reads", oe, 1);
                p = p + 1'b1;
            end
        end

        // write protect
        wp_n = 1'b0;
        wait_clk(5);
        chk(nv_wr_allow == 1'b0, "R8 protect low blocks", nv_wr_allow, 0);
        wp_n = 1'b1;
        wait_clk(5);
        chk(nv_wr_allow == 1'b1, "R8 protect high allows", nv_wr_allow, 1);

        // read in the middle of an address restarts the count
        restart_seq(sec);
        send_addr(16'h00FF);   // only bits reach count; then interrupt below
        // now in data at 0x0FF; start over with restart and partial address
        restart_seq(sec);
        for (int i = 0; i < 5; i++) wr_bit(1'b1);
        rd_bit(b, oe);
        chk(b == 1'b1, "R3 R7 read mid-address is 1", b, 1);
        send_addr(16'h8003);
        rd_byte(v, oe);
        chk(v == exp_byte(9'h003), "R3 count restarted after read", v, exp_byte(9'h003));

        // write without restart inside data phase is ignored
        restart_seq(sec);
        send_addr(16'h0010);
        rd_byte(v, oe);
        chk(v == exp_byte(9'h010), "R4 byte at 0x010", v, exp_byte(9'h010));
        wr_bit(1'b1);
        rd_byte(v, oe);
        chk(v == exp_byte(9'h011), "R10 write ignored", v, exp_byte(9'h011));

        // protocol error: both strobes low
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        wait_clk(5);
        chk(dio_oe == 1'b0, "R9 R2 hi-z on error", dio_oe, 0);
        chk(proto_err == 1'b1, "R9 error flagged", proto_err, 1);
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        wait_clk(6);
        chk(proto_err == 1'b0, "R9 error clears", proto_err, 0);
        rd_byte(v, oe);
        chk(v == exp_byte(9'h012), "R9 pointer unchanged by error", v, exp_byte(9'h012));

        // restart ignored while busy
        hw_reset();
        send_addr(16'h0020);   // power-up state collects an address directly
        rd_bit(b, oe);
        v = {7'b0, b};
        nv_busy = 1'b1;
        wait_clk(2);
        wr_bit(1'b0);
        nv_busy = 1'b0;
        wait_clk(2);
        for (int i = 0; i < 7; i++) begin
            rd_bit(b, oe);
            v = {v[6:0], b};
        end
        chk(v == exp_byte(9'h020), "R6 busy restart ignored", v, exp_byte(9'h020));
        rd_byte(v, oe);
        chk(v == exp_byte(9'h021), "R5 R6 stream continues", v, exp_byte(9'h021));
        chk(nv_wr_allow == 1'b0, "R6 latch not set while busy", nv_wr_allow, 0);

        // R1: a 1 bit sent as address MSB is not a restart and is counted
        restart_seq(sec);
        send_addr(16'hC1FF);
        rd_byte(v, oe);
        chk(v == exp_byte(9'h1FF), "R1 R3 address 0x1FF", v, exp_byte(9'h1FF));
        rd_byte(v, oe);
        chk(v == exp_byte(9'h000), "R5 wrap to 0x000", v, exp_byte(9'h000));

        finish_up();
    end

endmodule